// File: doc/BRIEF.md
# Lockstep Pair Guard with Standby Failover

This block sits between two self-checking processing pairs and a shared output bus. The primary pair and the standby pair each have two lanes that run in lockstep and produce a data word with a valid strobe. The guard compares the two lanes of each pair on every clock cycle. While the primary is healthy, its agreed word is forwarded to the bus one cycle later. When the primary lanes disagree, the guard raises a trap in that cycle, and no primary word reaches the bus from then on. The standby pair's word is forwarded instead. If the standby also fails while it drives the bus, the guard halts and the bus goes idle.

The guard also keeps its own copy of the protected state. This copy is a ring of the most recent words delivered on the bus. After a soft error on the primary, software can request a recovery. The guard then streams that copy, one word per cycle, into the primary pair's reload port, and hands the bus back to the primary when the stream ends. A sticky two-bit code records which pair failed first.

Top module: `dual_pair_guard`

## Requirements
- R1: After reset, `bus_vld`=0, `bus_data`=IDLE_WORD (0 by default), `trap`=0, `on_primary`=1, `on_standby`=0, `halted`=0, `fault_code`=00 and `reload_vld`=0.
- R2: The active pair's lanes are compared every cycle. When both strobes are high and the words are equal, the word appears on `bus_data` with `bus_vld`=1 at the next clock edge. When both strobes are low, `bus_vld` is 0 after that edge.
- R3: For the pair that currently drives the bus, a miscompare raises `trap` combinationally in the same cycle. A miscompare is either differing valid strobes, or both strobes high with differing words.
- R4: A primary miscompare with a usable standby decouples the primary at that edge. The standby's word from that same cycle is the next bus word, `on_standby`=1 from then on, and later primary inputs do not reach the bus.
- R5: A standby miscompare while the primary drives the bus raises no trap and leaves the bus unchanged, but it marks the standby unusable. A later primary miscompare then halts the guard.
- R6: A standby miscompare while the standby drives the bus (including during reload), or a primary miscompare with no usable standby, raises `trap`. After that edge `halted`=1, `bus_vld`=0 and `bus_data`=IDLE_WORD until reset, and `recover_req` has no effect.
- R7: `fault_code` records the first failing pair: 01 for the primary, 10 for the standby. A primary miscompare takes priority when both pairs fail in the same cycle. Only reset clears the code.
- R8: `recover_req` is ignored unless the standby drives the bus and no reload is in progress. While the primary drives the bus, it causes no reload and no change of source.
- R9: `recover_req` sampled while the standby drives the bus starts a reload at the next edge. For STATE_WORDS cycles, `reload_vld`=1 and `reload_idx` counts 0, 1, … STATE_WORDS-1. At the edge after the last reload cycle, `on_primary`=1 again.
- R10: The state copy is a ring of STATE_WORDS words that starts at zero with write slot 0. Each word delivered to the bus is stored in the current slot, and the slot then advances modulo STATE_WORDS. `reload_data` shows the stored word at `reload_idx`.
- R11: A standby miscompare during a reload aborts the reload: `reload_vld`=0 and `halted`=1 after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pri_a_data | input | DATA_W | Primary pair, lane A word |
| pri_a_vld | input | 1 | Primary pair, lane A valid |
| pri_b_data | input | DATA_W | Primary pair, lane B word |
| pri_b_vld | input | 1 | Primary pair, lane B valid |
| sby_a_data | input | DATA_W | Standby pair, lane A word |
| sby_a_vld | input | 1 | Standby pair, lane A valid |
| sby_b_data | input | DATA_W | Standby pair, lane B word |
| sby_b_vld | input | 1 | Standby pair, lane B valid |
| recover_req | input | 1 | Software request to reload and restore the primary |
| bus_data | output | DATA_W | Registered bus word |
| bus_vld | output | 1 | Registered bus word valid |
| trap | output | 1 | Same-cycle miscompare of the driving pair |
| on_primary | output | 1 | Primary pair drives the bus |
| on_standby | output | 1 | Standby pair drives the bus (including reload) |
| halted | output | 1 | Both pairs decoupled, bus idle |
| fault_code | output | 2 | Sticky first-failure code |
| reload_vld | output | 1 | Reload stream word valid |
| reload_idx | output | IDX_W | Reload stream slot index |
| reload_data | output | DATA_W | Reload stream word |

## Verification
The clocked properties take for granted that each lane's inputs are settled before the clock edge and stay steady through it. They also assume that `recover_req` only matters in the cycle in which it is sampled, so a request held over several cycles simply starts one reload. The stimulus meets these assumptions by changing every input at the falling edge. Both pairs are fed the same word unless a fault is injected on purpose, and reload cycles are run with both standby strobes low, so the state copy does not change during the stream it is read from.

// File: rtl/dpg_pkg.sv
package dpg_pkg;

    typedef enum logic [1:0] {
        MD_PRIMARY = 2'd0,
        MD_STANDBY = 2'd1,
        MD_RELOAD  = 2'd2,
        MD_HALT    = 2'd3
    } mode_e;

    localparam logic [1:0] FC_NONE    = 2'b00;
    localparam logic [1:0] FC_PRIMARY = 2'b01;
    localparam logic [1:0] FC_STANDBY = 2'b10;

endpackage

// File: rtl/dpg_lane_cmp.sv
module dpg_lane_cmp #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a_data,
    input  logic              a_vld,
    input  logic [DATA_W-1:0] b_data,
    input  logic              b_vld,
    output logic              word_ok,
    output logic              miscmp,
    output logic [DATA_W-1:0] word
);
    logic both_vld;
    logic same_word;

    always_comb begin
        both_vld  = a_vld & b_vld;
        same_word = (a_data == b_data);
        miscmp    = (a_vld ^ b_vld) | (both_vld & ~same_word);
        word_ok   = both_vld & same_word;
        word      = a_data;
    end
endmodule

// File: rtl/dpg_ckpt.sv
module dpg_ckpt #(
    parameter int DATA_W = 8,
    parameter int WORDS  = 4,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    typedef struct packed {
        logic [WORDS-1:0][DATA_W-1:0] mem;
        logic [IDX_W-1:0]             ptr;
    } ck_t;

    ck_t ck_d, ck_q;

    always_comb begin
        ck_d = ck_q;
        if (wr_en) begin
            ck_d.mem[ck_q.ptr] = wr_data;
            ck_d.ptr = (ck_q.ptr == LAST) ? '0 : ck_q.ptr + IDX_W'(1);
        end
        rd_data = ck_q.mem[rd_idx];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ck_q <= '0;
        else        ck_q <= ck_d;
    end

    p_ring_wrap_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && ck_q.ptr == LAST) |=> (ck_q.ptr == '0));

    p_ring_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ck_q.ptr));

    p_ring_store_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ck_q.mem[$past(ck_q.ptr)] == $past(wr_data)));
endmodule

// File: rtl/dpg_ctrl.sv
module dpg_ctrl
    import dpg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int WORDS  = 4,
    parameter logic [DATA_W-1:0] IDLE_WORD = '0,
    localparam int IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pri_ok,
    input  logic              pri_mis,
    input  logic [DATA_W-1:0] pri_word,
    input  logic              sby_ok,
    input  logic              sby_mis,
    input  logic [DATA_W-1:0] sby_word,
    input  logic              recover_req,
    input  logic [DATA_W-1:0] ckpt_rd_data,
    output logic              ckpt_we,
    output logic [DATA_W-1:0] ckpt_wdata,
    output logic [IDX_W-1:0]  ckpt_ridx,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_vld,
    output logic              trap,
    output mode_e             mode,
    output logic [1:0]        fault_code,
    output logic              reload_vld,
    output logic [IDX_W-1:0]  reload_idx,
    output logic [DATA_W-1:0] reload_data
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(WORDS - 1);

    typedef struct packed {
        mode_e             mode;
        logic              spare_ok;
        logic [1:0]        code;
        logic [IDX_W-1:0]  cnt;
        logic              bus_vld;
        logic [DATA_W-1:0] bus_data;
    } st_t;

    st_t st_d, st_q;
    logic              take;
    logic [DATA_W-1:0] word;

    always_comb begin
        st_d = st_q;
        trap = 1'b0;
        take = 1'b0;
        word = IDLE_WORD;

        if (st_q.code == FC_NONE) begin
            if (st_q.mode == MD_PRIMARY && pri_mis)  st_d.code = FC_PRIMARY;
            else if (st_q.mode != MD_HALT && sby_mis) st_d.code = FC_STANDBY;
        end

        unique case (st_q.mode)
            MD_PRIMARY: begin
                trap = pri_mis;
                if (pri_mis) begin
                    if (st_q.spare_ok && !sby_mis) begin
                        st_d.mode = MD_STANDBY;
                        take = sby_ok;
                        word = sby_word;
                    end else begin
                        st_d.mode = MD_HALT;
                    end
                end else begin
                    take = pri_ok;
                    word = pri_word;
                    if (sby_mis) st_d.spare_ok = 1'b0;
                end
            end
            MD_STANDBY: begin
                trap = sby_mis;
                if (sby_mis) begin
                    st_d.mode = MD_HALT;
                end else begin
                    take = sby_ok;
                    word = sby_word;
                    if (recover_req) begin
                        st_d.mode = MD_RELOAD;
                        st_d.cnt  = '0;
                    end
                end
            end
            MD_RELOAD: begin
                trap = sby_mis;
                if (sby_mis) begin
                    st_d.mode = MD_HALT;
                end else begin
                    take = sby_ok;
                    word = sby_word;
                    if (st_q.cnt == LAST) begin
                        st_d.mode = MD_PRIMARY;
                        st_d.cnt  = '0;
                    end else begin
                        st_d.cnt = st_q.cnt + IDX_W'(1);
                    end
                end
            end
            default: begin
                trap = 1'b0;
            end
        endcase

        st_d.bus_vld  = take;
        st_d.bus_data = take ? word : IDLE_WORD;

        ckpt_we     = take;
        ckpt_wdata  = word;
        ckpt_ridx   = st_q.cnt;
        bus_data    = st_q.bus_data;
        bus_vld     = st_q.bus_vld;
        mode        = st_q.mode;
        fault_code  = st_q.code;
        reload_vld  = (st_q.mode == MD_RELOAD);
        reload_idx  = st_q.cnt;
        reload_data = ckpt_rd_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{mode: MD_PRIMARY, spare_ok: 1'b1, code: FC_NONE,
                      cnt: '0, bus_vld: 1'b0, bus_data: IDLE_WORD};
        end else begin
            st_q <= st_d;
        end
    end

    p_forward_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_PRIMARY && pri_ok) |=> (bus_vld && bus_data == $past(pri_word)));

    p_decouple_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_PRIMARY && pri_mis) |=> (st_q.mode != MD_PRIMARY));

    p_halt_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_HALT) |=> (st_q.mode == MD_HALT && !bus_vld && bus_data == IDLE_WORD));

    p_code_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.code != FC_NONE) |=> $stable(st_q.code));

    p_recover_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_PRIMARY && !pri_mis) |=> (st_q.mode == MD_PRIMARY));

    p_reload_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_RELOAD && st_q.cnt != LAST && !sby_mis)
            |=> (st_q.mode == MD_RELOAD && st_q.cnt == $past(st_q.cnt) + IDX_W'(1)));

    p_reload_abort_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == MD_RELOAD && sby_mis) |=> (st_q.mode == MD_HALT));
endmodule

// File: rtl/dual_pair_guard.sv
module dual_pair_guard
    import dpg_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int STATE_WORDS = 4,
    parameter logic [DATA_W-1:0] IDLE_WORD = '0,
    localparam int IDX_W = (STATE_WORDS > 1) ? $clog2(STATE_WORDS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pri_a_data,
    input  logic              pri_a_vld,
    input  logic [DATA_W-1:0] pri_b_data,
    input  logic              pri_b_vld,
    input  logic [DATA_W-1:0] sby_a_data,
    input  logic              sby_a_vld,
    input  logic [DATA_W-1:0] sby_b_data,
    input  logic              sby_b_vld,
    input  logic              recover_req,
    output logic [DATA_W-1:0] bus_data,
    output logic              bus_vld,
    output logic              trap,
    output logic              on_primary,
    output logic              on_standby,
    output logic              halted,
    output logic [1:0]        fault_code,
    output logic              reload_vld,
    output logic [IDX_W-1:0]  reload_idx,
    output logic [DATA_W-1:0] reload_data
);
    localparam int NPAIR = 2;

    logic [NPAIR-1:0][DATA_W-1:0] a_data, b_data, p_word;
    logic [NPAIR-1:0]             a_vld, b_vld, p_ok, p_mis;

    assign a_data[0] = pri_a_data;
    assign a_vld[0]  = pri_a_vld;
    assign b_data[0] = pri_b_data;
    assign b_vld[0]  = pri_b_vld;
    assign a_data[1] = sby_a_data;
    assign a_vld[1]  = sby_a_vld;
    assign b_data[1] = sby_b_data;
    assign b_vld[1]  = sby_b_vld;

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        dpg_lane_cmp #(.DATA_W(DATA_W)) u_cmp (
            .a_data  (a_data[g]),
            .a_vld   (a_vld[g]),
            .b_data  (b_data[g]),
            .b_vld   (b_vld[g]),
            .word_ok (p_ok[g]),
            .miscmp  (p_mis[g]),
            .word    (p_word[g])
        );
    end

    logic              ck_we;
    logic [DATA_W-1:0] ck_wdata, ck_rdata;
    logic [IDX_W-1:0]  ck_ridx;
    mode_e             mode;

    dpg_ckpt #(.DATA_W(DATA_W), .WORDS(STATE_WORDS)) u_ckpt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ck_we),
        .wr_data (ck_wdata),
        .rd_idx  (ck_ridx),
        .rd_data (ck_rdata)
    );

    dpg_ctrl #(.DATA_W(DATA_W), .WORDS(STATE_WORDS), .IDLE_WORD(IDLE_WORD)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .pri_ok       (p_ok[0]),
        .pri_mis      (p_mis[0]),
        .pri_word     (p_word[0]),
        .sby_ok       (p_ok[1]),
        .sby_mis      (p_mis[1]),
        .sby_word     (p_word[1]),
        .recover_req  (recover_req),
        .ckpt_rd_data (ck_rdata),
        .ckpt_we      (ck_we),
        .ckpt_wdata   (ck_wdata),
        .ckpt_ridx    (ck_ridx),
        .bus_data     (bus_data),
        .bus_vld      (bus_vld),
        .trap         (trap),
        .mode         (mode),
        .fault_code   (fault_code),
        .reload_vld   (reload_vld),
        .reload_idx   (reload_idx),
        .reload_data  (reload_data)
    );

    always_comb begin
        on_primary = (mode == MD_PRIMARY);
        on_standby = (mode == MD_STANDBY) || (mode == MD_RELOAD);
        halted     = (mode == MD_HALT);
    end

    p_flags_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({on_primary, on_standby, halted}));
endmodule

// File: tb/tb_dual_pair_guard.sv
`timescale 1ns/1ps
module tb_dual_pair_guard;
    localparam int DW = 8;
    localparam int NW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0] pad = '0, pbd = '0, sad = '0, sbd = '0;
    logic pav = 1'b0, pbv = 1'b0, sav = 1'b0, sbv = 1'b0, rec = 1'b0;
    logic [DW-1:0] bus_data, reload_data;
    logic bus_vld, trap, on_primary, on_standby, halted, reload_vld;
    logic [1:0] fault_code;
    logic [1:0] reload_idx;

    always #2.5 clk = ~clk;

    dual_pair_guard #(.DATA_W(DW), .STATE_WORDS(NW)) dut (
        .clk(clk), .rst_n(rst_n),
        .pri_a_data(pad), .pri_a_vld(pav), .pri_b_data(pbd), .pri_b_vld(pbv),
        .sby_a_data(sad), .sby_a_vld(sav), .sby_b_data(sbd), .sby_b_vld(sbv),
        .recover_req(rec),
        .bus_data(bus_data), .bus_vld(bus_vld), .trap(trap),
        .on_primary(on_primary), .on_standby(on_standby), .halted(halted),
        .fault_code(fault_code), .reload_vld(reload_vld),
        .reload_idx(reload_idx), .reload_data(reload_data)
    );

    int n_run = 0;
    int n_fail = 0;

    // reference model: mode 0 primary, 1 standby, 2 reload, 3 halted
    int m_mode, m_cnt, m_ptr;
    bit m_spare;
    logic [1:0] m_code;
    logic [DW-1:0] m_ck [NW];
    logic m_vld;
    logic [DW-1:0] m_data;

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", what, act, exp);
        end
    endtask

    task automatic model_reset();
        m_mode = 0; m_cnt = 0; m_ptr = 0; m_spare = 1'b1; m_code = 2'b00;
        m_vld = 1'b0; m_data = '0;
        for (int i = 0; i < NW; i++) m_ck[i] = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; pav = 0; pbv = 0; sav = 0; sbv = 0; rec = 0;
        pad = '0; pbd = '0; sad = '0; sbd = '0;
        repeat (3) @(posedge clk);
        model_reset();
        #1;
        chk(bus_vld == 1'b0 && bus_data == '0, "R1 bus after reset", {bus_vld, bus_data}, 0);
        chk(on_primary && !on_standby && !halted, "R1 flags after reset",
            {on_primary, on_standby, halted}, 3'b100);
        chk(fault_code == 2'b00 && !reload_vld, "R1 code/reload after reset",
            {fault_code, reload_vld}, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic step(input logic [DW-1:0] ma, input logic mav, input logic [DW-1:0] mb,
                        input logic mbv, input logic [DW-1:0] sa, input logic sva,
                        input logic [DW-1:0] sb, input logic svb, input logic rq);
        bit mmis, mok, smis, sok, take, exp_trap;
        logic [DW-1:0] w;
        @(negedge clk);
        pad = ma; pav = mav; pbd = mb; pbv = mbv;
        sad = sa; sav = sva; sbd = sb; sbv = svb; rec = rq;
        #1;
        mmis = (mav != mbv) || (mav && mbv && ma != mb);
        mok  = mav && mbv && ma == mb;
        smis = (sva != svb) || (sva && svb && sa != sb);
        sok  = sva && svb && sa == sb;
        exp_trap = (m_mode == 0 && mmis) || ((m_mode == 1 || m_mode == 2) && smis);
        chk(trap == exp_trap, "R3 trap same cycle", trap, exp_trap);
        chk(reload_vld == (m_mode == 2), "R9 reload_vld", reload_vld, (m_mode == 2));
        if (m_mode == 2) begin
            chk(reload_idx == m_cnt[1:0], "R9 reload_idx", reload_idx, m_cnt);
            chk(reload_data == m_ck[m_cnt], "R10 reload_data", reload_data, m_ck[m_cnt]);
        end
        // model update for the coming edge
        take = 1'b0; w = '0;
        if (m_code == 2'b00) begin
            if (m_mode == 0 && mmis) m_code = 2'b01;
            else if (m_mode != 3 && smis) m_code = 2'b10;
        end
        case (m_mode)
            0: if (mmis) begin
                   if (m_spare && !smis) begin m_mode = 1; take = sok; w = sa; end
                   else m_mode = 3;
               end else begin
                   take = mok; w = ma;
                   if (smis) m_spare = 1'b0;
               end
            1: if (smis) m_mode = 3;
               else begin
                   take = sok; w = sa;
                   if (rq) begin m_mode = 2; m_cnt = 0; end
               end
            2: if (smis) m_mode = 3;
               else begin
                   take = sok; w = sa;
                   if (m_cnt == NW - 1) begin m_mode = 0; m_cnt = 0; end
                   else m_cnt++;
               end
            default: ;
        endcase
        if (take) begin
            m_ck[m_ptr] = w;
            m_ptr = (m_ptr + 1) % NW;
        end
        m_vld = take;
        m_data = take ? w : '0;
        @(posedge clk);
        #1;
        chk(bus_vld == m_vld, "R2 bus_vld", bus_vld, m_vld);
        chk(bus_data == m_data, "R2 bus_data", bus_data, m_data);
        chk(on_primary == (m_mode == 0) && on_standby == (m_mode == 1 || m_mode == 2)
            && halted == (m_mode == 3), "R4 source flags",
            {on_primary, on_standby, halted}, m_mode);
        chk(fault_code == m_code, "R7 fault_code", fault_code, m_code);
    endtask

    task automatic good(input logic [DW-1:0] w);
        step(w, 1, w, 1, w, 1, w, 1, 0);
    endtask

    task automatic sby_only(input logic [DW-1:0] w, input logic rq);
        step(8'hEE, 1, 8'h11, 1, w, 1, w, 1, rq);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired act=1 exp=0");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        // R2 / R10: full word sweep on a healthy primary, plus idle cycles
        do_reset();
        for (int w = 0; w < 256; w++) good(8'(w));
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk(bus_vld == 1'b0, "R2 idle gives no word", bus_vld, 0);

        // R3 / R4: every primary miscompare kind, failover to standby
        for (int k = 0; k < 3; k++) begin
            do_reset();
            good(8'h10); good(8'h20);
            case (k)
                0: step(8'h33, 1, 8'h33, 0, 8'hA5, 1, 8'hA5, 1, 0);
                1: step(8'h33, 0, 8'h33, 1, 8'hA5, 1, 8'hA5, 1, 0);
                default: step(8'h33, 1, 8'h34, 1, 8'hA5, 1, 8'hA5, 1, 0);
            endcase
            chk(bus_data == 8'hA5 && on_standby, "R4 standby word on failover", bus_data, 8'hA5);
            for (int j = 0; j < 4; j++) step(8'h77, 1, 8'h77, 1, 8'(8'h40 + j), 1, 8'(8'h40 + j), 1, 0);
            chk(bus_data == 8'h43, "R4 primary ignored after decouple", bus_data, 8'h43);
            chk(fault_code == 2'b01, "R7 primary code", fault_code, 2'b01);
        end

        // R8: recover request while primary drives has no effect
        do_reset();
        good(8'h01);
        step(8'h02, 1, 8'h02, 1, 8'h02, 1, 8'h02, 1, 1);
        good(8'h03);
        chk(on_primary && !reload_vld, "R8 recover ignored on primary", on_primary, 1);

        // R9 / R10: recovery stream and hand-back
        do_reset();
        for (int j = 0; j < 6; j++) good(8'(8'hC0 + j));
        step(8'h00, 1, 8'h01, 1, 8'hD0, 1, 8'hD0, 1, 0);
        sby_only(8'hD1, 0);
        sby_only(8'hD2, 1);
        for (int j = 0; j < NW; j++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk(on_primary && !reload_vld, "R9 control returned to primary", on_primary, 1);
        good(8'h5C);
        chk(bus_data == 8'h5C, "R9 primary word after reload", bus_data, 8'h5C);
        step(8'h01, 1, 8'h02, 1, 8'h66, 1, 8'h66, 1, 0);
        chk(fault_code == 2'b01 && on_standby, "R7 code kept on second fault", fault_code, 2'b01);

        // R5: standby fault while standing by
        do_reset();
        good(8'h21);
        step(8'h22, 1, 8'h22, 1, 8'h22, 1, 8'h23, 1, 0);
        chk(bus_data == 8'h22 && on_primary, "R5 bus unchanged by standby fault", bus_data, 8'h22);
        chk(fault_code == 2'b10, "R7 standby code", fault_code, 2'b10);
        good(8'h24);
        step(8'h25, 1, 8'h26, 1, 8'h25, 1, 8'h25, 1, 0);
        chk(halted && !bus_vld, "R5 no usable standby halts", halted, 1);

        // R6: standby fault while driving, then recover ignored
        do_reset();
        step(8'h01, 1, 8'h02, 1, 8'h90, 1, 8'h90, 1, 0);
        sby_only(8'h91, 0);
        step(0, 0, 0, 0, 8'h92, 1, 8'h92, 0, 0);
        chk(halted && !bus_vld && bus_data == 8'h00, "R6 halted idle", {halted, bus_vld}, 2'b10);
        sby_only(8'h93, 1);
        good(8'h94);
        chk(halted && !reload_vld && bus_data == 8'h00, "R6 stays halted", halted, 1);

        // R7: both pairs fail in the same cycle -> primary priority, halt
        do_reset();
        step(8'h01, 1, 8'h02, 1, 8'h03, 0, 8'h03, 1, 0);
        chk(fault_code == 2'b01 && halted, "R7 primary priority", fault_code, 2'b01);

        // R11: standby fault during reload
        do_reset();
        good(8'hB0);
        step(8'h01, 1, 8'h02, 1, 8'hB1, 1, 8'hB1, 1, 0);
        sby_only(8'hB2, 1);
        step(0, 0, 0, 0, 0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 8'h01, 1, 8'h02, 1, 0);
        chk(halted && !reload_vld, "R11 reload aborted", {halted, reload_vld}, 2'b10);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule